// File: doc/BRIEF.md
# Scanline Sprite Evaluation Unit

This unit picks the objects that will appear on the next line of a raster display. An object table of 64 entries, four bytes each, sits outside the block. The block reads it one byte per clock through a plain read port. Byte 0 of every entry holds the object's top row. While the evaluation window input is high, the block walks the entries from index 0 upward. It compares each top row with the number of the line to be drawn. Every entry that covers that line is copied whole into a small secondary table of 8 four-byte slots.

When the window opens, the block clears the secondary table to 0xFF and zeroes its count and flags. It then spends one cycle on an entry that misses and four cycles on an entry that hits. In the worst case the walk takes 89 cycles, which fits well inside a 192-dot window. The outputs stay frozen between windows, so the pixel pipeline can read them during the following line. The outputs are the flattened secondary table, the number of objects found, an overflow flag and a flag showing that entry 0 was selected.

Top module: `obj_line_scan`

## Requirements
- R1: After reset, every secondary byte reads 0xFF, the count is 0, and the overflow and entry-0 flags are 0.
- R2: On the first clock edge at which `eval_en` is high after being low, all 32 secondary bytes become 0xFF and the count and both flags become 0. Scanning starts at the next edge.
- R3: An entry with top row Y covers line L exactly when L >= Y and L - Y < H. H is 8 when `tall` is 0 and 16 when `tall` is 1. The comparison is unsigned over 9 bits, so a Y above L never matches.
- R4: Entries are examined in ascending index order. The address of byte j of entry e is 4*e + j, and `rd_data` must return that byte in the same cycle. A matching entry's bytes 0..3 go to slot k = current count, at `sec_flat[32k+8j +: 8]`.
- R5: At most 8 entries are copied, and `obj_cnt` equals the number of fully copied entries (0..8).
- R6: When a ninth matching entry is met, `overflow` goes to 1, nothing more is written and the scan stops. Exactly eight matches leave `overflow` at 0.
- R7: `obj0_sel` is 1 after a window exactly when entry 0 matched and was copied.
- R8: Timing: the edge after the clear edge examines entry 0. A non-matching entry uses one edge, and a matching entry uses four edges, one per byte. The count rises on the edge that writes byte 3.
- R9: While `eval_en` is low, the secondary table, count and flags hold their values, whatever happens to `next_line`, `tall` or the table contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Active-low synchronous reset |
| eval_en | input | 1 | Evaluation window; its rising edge restarts the scan |
| next_line | input | 8 | Line number being prepared |
| tall | input | 1 | 0: objects are 8 rows high, 1: 16 rows high |
| rd_addr | output | 8 | Object table byte address (4*entry + byte) |
| rd_data | input | 8 | Object table byte at `rd_addr`, same cycle |
| sec_flat | output | 256 | Secondary table, byte n at bits [8n+7:8n] |
| obj_cnt | output | 4 | Objects copied this window |
| overflow | output | 1 | A ninth matching entry was found |
| obj0_sel | output | 1 | Entry 0 was copied |

## Verification
The assertions assume that the object table answers a read in the same cycle. They also assume that `next_line`, `tall` and the table contents do not change while a window is open. The bench writes the table and sets the line and height only while `eval_en` is low, and changes `eval_en` only on falling clock edges. Windows are either long enough to finish the walk or deliberately cut short, and the expected partial results for short windows follow from the per-entry cycle costs.

// File: rtl/obj_line_scan.sv
module obj_line_scan #(
  parameter int OBJ_N = 64,
  parameter int SLOTS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 eval_en,
  input  logic [7:0]           next_line,
  input  logic                 tall,
  output logic [7:0]           rd_addr,
  input  logic [7:0]           rd_data,
  output logic [SLOTS*32-1:0]  sec_flat,
  output logic [3:0]           obj_cnt,
  output logic                 overflow,
  output logic                 obj0_sel
);
  localparam int IDX_W  = $clog2(OBJ_N) + 1;
  localparam int SLOT_W = $clog2(SLOTS);
  localparam int SEC_B  = SLOTS * 4;

  logic [7:0]       sec [SEC_B];
  logic [IDX_W-1:0] idx;
  logic [1:0]       ph;
  logic [3:0]       cnt;
  logic             en_q, ovf, obj0;

  logic [8:0] diff;
  logic       start, scan, hit, full;

  assign start = eval_en & ~en_q;
  assign scan  = eval_en & en_q & ~idx[IDX_W-1] & ~ovf;
  assign diff  = {1'b0, next_line} - {1'b0, rd_data};
  assign hit   = ~diff[8] & (diff[7:0] < (tall ? 8'd16 : 8'd8));
  assign full  = (cnt == 4'(SLOTS));

  assign rd_addr  = 8'({idx[IDX_W-2:0], ph});
  assign obj_cnt  = cnt;
  assign overflow = ovf;
  assign obj0_sel = obj0;

  for (genvar g = 0; g < SEC_B; g++) begin : g_flat
    assign sec_flat[8*g +: 8] = sec[g];
  end

  always_ff @(posedge clk) begin
    if (!rst_n || start) begin
      idx  <= '0;
      ph   <= '0;
      cnt  <= '0;
      ovf  <= 1'b0;
      obj0 <= 1'b0;
      for (int i = 0; i < SEC_B; i++) sec[i] <= 8'hFF;
    end else if (scan) begin
      if (ph == 2'd0) begin
        if (hit && full) begin
          ovf <= 1'b1;
        end else if (hit) begin
          sec[{cnt[SLOT_W-1:0], 2'b00}] <= rd_data;
          ph <= 2'd1;
          if (idx == '0) obj0 <= 1'b1;
        end else begin
          idx <= idx + 1'b1;
        end
      end else begin
        sec[{cnt[SLOT_W-1:0], ph}] <= rd_data;
        ph <= ph + 2'd1;
        if (ph == 2'd3) begin
          cnt <= cnt + 4'd1;
          idx <= idx + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= eval_en;
  end

  // R5
  cnt_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    obj_cnt <= 4'(SLOTS));

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> obj_cnt == 4'(SLOTS));

  // R2
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_en && !en_q) |=> (obj_cnt == 4'd0 && !overflow && !obj0_sel && &sec_flat));

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!eval_en) |-> ($stable(sec_flat) && $stable(obj_cnt) && $stable(overflow) && $stable(obj0_sel)));

  // R8
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(eval_en && en_q) |-> ((obj_cnt - $past(obj_cnt)) <= 4'd1));

  // R7
  obj0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    obj0_sel |-> (obj_cnt != 4'd0 || ph != 2'd0));
endmodule

// File: tb/sim_obj_line_scan.sv
module sim_obj_line_scan;
  localparam int CLK_P = 10;
  localparam int WIN   = 192;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         eval_en = 1'b0;
  logic [7:0]   next_line = 8'd0;
  logic         tall = 1'b0;
  logic [7:0]   rd_addr, rd_data;
  logic [255:0] sec_flat;
  logic [3:0]   obj_cnt;
  logic         overflow, obj0_sel;

  logic [7:0]   oam [256];
  logic [255:0] exp_sec;
  int           exp_cnt;
  logic         exp_ovf, exp_obj0;
  int           checks = 0, fails = 0;

  always #(CLK_P/2) clk = ~clk;
  assign rd_data = oam[rd_addr];

  obj_line_scan u0 (
    .clk(clk), .rst_n(rst_n), .eval_en(eval_en), .next_line(next_line), .tall(tall),
    .rd_addr(rd_addr), .rd_data(rd_data), .sec_flat(sec_flat), .obj_cnt(obj_cnt),
    .overflow(overflow), .obj0_sel(obj0_sel)
  );

  task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic fill_far();
    for (int e = 0; e < 64; e++) begin
      oam[4*e] = 8'hF0;
      for (int b = 1; b < 4; b++) oam[4*e+b] = 8'((e * 7 + b * 3 + 1) ^ 8'h5A);
    end
  endtask

  task automatic model();
    int h = tall ? 16 : 8;
    exp_sec = '1; exp_cnt = 0; exp_ovf = 1'b0; exp_obj0 = 1'b0;
    for (int e = 0; e < 64; e++) begin
      int d = int'(next_line) - int'(oam[4*e]);
      if (d >= 0 && d < h) begin
        if (exp_cnt == 8) begin exp_ovf = 1'b1; break; end
        for (int b = 0; b < 4; b++) exp_sec[32*exp_cnt + 8*b +: 8] = oam[4*e+b];
        if (e == 0) exp_obj0 = 1'b1;
        exp_cnt++;
      end
    end
  endtask

  task automatic window(input int n);
    @(negedge clk) eval_en = 1'b1;
    repeat (n) @(posedge clk);
    @(negedge clk) eval_en = 1'b0;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic cmp_model(input string req);
    model();
    chk({req, " table"}, sec_flat, exp_sec);
    chk({req, " count"}, 256'(obj_cnt), 256'(exp_cnt));
    chk({req, " overflow"}, 256'(overflow), 256'(exp_ovf));
    chk({req, " obj0"}, 256'(obj0_sel), 256'(exp_obj0));
  endtask

  task automatic t_reset();
    chk("R1 table", sec_flat, '1);
    chk("R1 count", 256'(obj_cnt), 256'd0);
    chk("R1 flags", 256'({overflow, obj0_sel}), 256'd0);
  endtask

  task automatic t_basic();
    fill_far(); next_line = 8'd100; tall = 1'b0;
    oam[12] = 8'd95; oam[40] = 8'd100; oam[80] = 8'd93;
    window(WIN);
    cmp_model("R4");
    chk("R5 count three", 256'(obj_cnt), 256'd3);
    chk("R4 slot0 byte0", 256'(sec_flat[7:0]), 256'd95);
    chk("R4 slot2 byte3", 256'(sec_flat[32*2+24 +: 8]), 256'(oam[83]));
  endtask

  task automatic t_bounds();
    fill_far(); next_line = 8'd50; tall = 1'b0;
    oam[4] = 8'd50; oam[8] = 8'd43; oam[12] = 8'd42; oam[16] = 8'd51;
    oam[20] = 8'd35; oam[24] = 8'd34; oam[28] = 8'd250;
    window(WIN);
    chk("R3 h8 count", 256'(obj_cnt), 256'd2);
    cmp_model("R3 h8");
    tall = 1'b1;
    window(WIN);
    chk("R3 h16 count", 256'(obj_cnt), 256'd4);
    cmp_model("R3 h16");
  endtask

  task automatic t_over();
    fill_far(); next_line = 8'd30; tall = 1'b0;
    for (int e = 2; e < 12; e++) oam[4*e] = 8'd30;
    window(WIN);
    chk("R6 overflow set", 256'(overflow), 256'd1);
    chk("R6 count eight", 256'(obj_cnt), 256'd8);
    cmp_model("R6");
    fill_far();
    for (int e = 50; e < 58; e++) oam[4*e] = 8'd27;
    window(WIN);
    chk("R6 eight no overflow", 256'(overflow), 256'd0);
    cmp_model("R6 exact");
  endtask

  task automatic t_obj0();
    fill_far(); next_line = 8'd10; tall = 1'b1;
    oam[0] = 8'd0;
    window(WIN);
    chk("R7 entry0 chosen", 256'(obj0_sel), 256'd1);
    oam[0] = 8'hF0; oam[4] = 8'd0;
    window(WIN);
    chk("R7 entry0 absent", 256'(obj0_sel), 256'd0);
    chk("R7 count", 256'(obj_cnt), 256'd1);
  endtask

  task automatic t_restart();
    fill_far(); next_line = 8'd60; tall = 1'b0;
    for (int e = 0; e < 12; e++) oam[4*e] = 8'd60;
    window(WIN);
    fill_far();
    window(WIN);
    chk("R2 table cleared", sec_flat, '1);
    chk("R2 count zero", 256'(obj_cnt), 256'd0);
    chk("R2 flags zero", 256'({overflow, obj0_sel}), 256'd0);
  endtask

  task automatic t_timing();
    fill_far(); next_line = 8'd20; tall = 1'b0;
    oam[0] = 8'd20; oam[4] = 8'd18;
    window(5);
    chk("R8 five edges count", 256'(obj_cnt), 256'd1);
    chk("R8 slot1 untouched", 256'(sec_flat[63:32]), 256'hFFFF_FFFF);
    window(4);
    chk("R8 four edges count", 256'(obj_cnt), 256'd0);
    chk("R8 partial bytes", 256'(sec_flat[31:0]), 256'({8'hFF, oam[2], oam[1], oam[0]}));
    window(9);
    chk("R8 nine edges count", 256'(obj_cnt), 256'd2);
    oam[0] = 8'hF0;
    window(6);
    chk("R8 miss costs one edge", 256'(obj_cnt), 256'd1);
  endtask

  task automatic t_hold();
    logic [255:0] s;
    logic [3:0]   c;
    fill_far(); next_line = 8'd70; tall = 1'b0;
    oam[8] = 8'd66; oam[0] = 8'd70;
    window(WIN);
    s = sec_flat; c = obj_cnt;
    next_line = 8'd3; tall = 1'b1;
    for (int e = 0; e < 64; e++) oam[4*e] = 8'd0;
    repeat (20) @(negedge clk);
    chk("R9 table held", sec_flat, s);
    chk("R9 count held", 256'(obj_cnt), 256'(c));
    chk("R9 obj0 held", 256'(obj0_sel), 256'd1);
  endtask

  initial begin
    fill_far();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_bounds();
    t_over();
    t_obj0();
    t_restart();
    t_timing();
    t_hold();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule